// File: doc/BRIEF.md
# Linked-List Command DMA Walker

This block is a fetch engine that follows a chain of command packets kept in RAM and streams the packet payloads to a graphics command port. Software-side logic hands it a base address and a one-cycle start pulse together with the channel's direction and destination port. The walker then reads one packet header, reads the payload words the header announces, and offers each payload word on a valid/ready output stream. When a packet is finished it either jumps to the next packet, using the pointer held in the header, or stops and raises a one-cycle done pulse.

Each 32-bit header carries three things. The top byte is the payload length in words. Bit 23 marks the final packet. The low bits form the address of the next header. All RAM addresses are word aligned and confined to a 2 MiB window. Every address the walker issues is therefore masked to bits [20:2]. RAM is reached through a request/valid pair: the request and its address stay up until the response arrives. The walker has at most one read outstanding, and it never holds a read and a pending output word at the same time.

The walk is only legal for a memory-to-device transfer aimed at the graphics port. A start with any other setting produces an error pulse and no bus activity.

Top module: `cmd_list_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `mem_req_o`, `cmd_valid_o`, `done_o` and `err_o` are all low.
- R2: The first read after an accepted start is issued the following cycle, at address `base_i & 0x1FFFFC`.
- R3: Header bits [31:24] give N, the number of payload words. These are read one after another at the previous address plus 4, masked with 0x1FFFFC, so the address wraps from 0x1FFFFC to 0x000000.
- R4: Every payload word is presented on `cmd_data_o` exactly once and in fetch order. While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o` stays high and `cmd_data_o` does not change.
- R5: When the last packet's payload is accepted (header bit 23 = 1), `done_o` is high for exactly one cycle, and `busy_o` is low the cycle after.
- R6: When header bit 23 = 0, the next header is read at `header & 0x1FFFFC`. Header bits 22:21 are ignored.
- R7: A header with N = 0 forwards no word, but it still either chains to the next header or terminates according to bit 23.
- R8: If a start arrives while `dir_from_ram_i` = 0, or while `port_i` is not 2 (the graphics port code), `err_o` pulses for one cycle in the next cycle. No RAM read is issued, no word is output, no done pulse follows, and `busy_o` stays low.
- R9: `mem_req_o` and `mem_addr_o` hold steady until `mem_valid_i` is seen. `mem_req_o` and `cmd_valid_o` are never high together.
- R10: A start pulse that arrives while the walker is busy is ignored. The walk in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a walk |
| base_i | input | 32 | Address of the first header (masked internally) |
| dir_from_ram_i | input | 1 | 1 = memory-to-device direction |
| port_i | input | 3 | Destination port code; 2 = graphics |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at walk end |
| err_o | output | 1 | One-cycle pulse on an illegal start |
| mem_req_o | output | 1 | RAM read request, held until answered |
| mem_addr_o | output | 21 | Word-aligned RAM read address |
| mem_valid_i | input | 1 | RAM read data valid, completes the request |
| mem_data_i | input | 32 | RAM read data |
| cmd_valid_o | output | 1 | Payload word available |
| cmd_data_o | output | 32 | Payload word |
| cmd_ready_i | input | 1 | Command port accepts the word |

## Verification
The timing of each result is fixed relative to its trigger:
- A request follows a start by one cycle, and the error pulse follows an illegal start by one cycle.
- A payload word appears on the stream the cycle after its RAM response.
- The next request follows a stream acceptance by one cycle.
- The done pulse follows either the final acceptance or a zero-length terminating header response by one cycle.

The bench drives and samples on the falling edge. It checks the request and the error pulse at the first falling edge after the start. It checks that done lasts a single cycle by looking at the falling edge after it. The RAM model, with latencies of 0 to 3 cycles, logs every address it answers. The sink, with several ready patterns, logs every accepted word. These logs are compared with lists that the bench computes by walking its own memory image.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_HDR = 3'd1,
        ST_FETCH_PAY = 3'd2,
        ST_PUSH      = 3'd3,
        ST_DONE      = 3'd4
    } walk_st_e;

endpackage

// File: rtl/lldma_cfg_check.sv
module lldma_cfg_check #(
    parameter int PORT_W   = 3,
    parameter int GFX_PORT = 2
) (
    input  logic              dir_from_ram_i,
    input  logic [PORT_W-1:0] port_i,
    output logic              cfg_ok_o
);
    localparam logic [PORT_W-1:0] GFX_CODE = PORT_W'(GFX_PORT);

    always_comb begin
        cfg_ok_o = dir_from_ram_i && (port_i == GFX_CODE);
    end
endmodule

// File: rtl/lldma_hdr_unpack.sv
module lldma_hdr_unpack #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 21,
    parameter int LEN_W    = 8,
    parameter int TERM_BIT = 23
) (
    input  logic [DATA_W-1:0] hdr_i,
    output logic [LEN_W-1:0]  len_o,
    output logic              term_o,
    output logic [ADDR_W-1:0] next_o
);
    localparam int LEN_LSB = DATA_W - LEN_W;
    localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

    logic unused_hdr_bits;

    always_comb begin
        len_o  = hdr_i[DATA_W-1:LEN_LSB];
        term_o = hdr_i[TERM_BIT];
        next_o = hdr_i[ADDR_W-1:0] & WORD_MASK;
    end

    assign unused_hdr_bits = ^hdr_i[TERM_BIT-1:ADDR_W];
endmodule

// File: rtl/lldma_addr_unit.sv
module lldma_addr_unit #(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] cur_i,
    output logic [ADDR_W-1:0] base_aligned_o,
    output logic [ADDR_W-1:0] step_o
);
    localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};
    localparam logic [ADDR_W-1:0] WORD_INC  = ADDR_W'(4);

    always_comb begin
        base_aligned_o = base_i & WORD_MASK;
        step_o         = (cur_i + WORD_INC) & WORD_MASK;
    end
endmodule

// File: rtl/cmd_list_walker.sv
module cmd_list_walker #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 21,
    parameter int LEN_W    = 8,
    parameter int TERM_BIT = 23,
    parameter int PORT_W   = 3,
    parameter int GFX_PORT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       base_i,
    input  logic              dir_from_ram_i,
    input  logic [PORT_W-1:0] port_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              cmd_valid_o,
    output logic [DATA_W-1:0] cmd_data_o,
    input  logic              cmd_ready_i
);
    import lldma_pkg::*;

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nxt;
        logic [LEN_W-1:0]  cnt;
        logic              term;
        logic [DATA_W-1:0] data;
        logic              err;
    } walk_s;

    walk_s walk_d, walk_q;

    logic              cfg_ok;
    logic [LEN_W-1:0]  hdr_len;
    logic              hdr_term;
    logic [ADDR_W-1:0] hdr_next;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] step_addr;
    logic              unused_base_hi;

    assign unused_base_hi = ^base_i[31:ADDR_W];

    lldma_cfg_check #(.PORT_W(PORT_W), .GFX_PORT(GFX_PORT)) u_cfg (
        .dir_from_ram_i (dir_from_ram_i),
        .port_i         (port_i),
        .cfg_ok_o       (cfg_ok)
    );

    lldma_hdr_unpack #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TERM_BIT(TERM_BIT)) u_hdr (
        .hdr_i  (mem_data_i),
        .len_o  (hdr_len),
        .term_o (hdr_term),
        .next_o (hdr_next)
    );

    lldma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .base_i         (base_i[ADDR_W-1:0]),
        .cur_i          (walk_q.addr),
        .base_aligned_o (start_addr),
        .step_o         (step_addr)
    );

    always_comb begin
        walk_d     = walk_q;
        walk_d.err = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (cfg_ok) begin
                        walk_d.st   = ST_FETCH_HDR;
                        walk_d.addr = start_addr;
                    end else begin
                        walk_d.err = 1'b1;
                    end
                end
            end
            ST_FETCH_HDR: begin
                if (mem_valid_i) begin
                    walk_d.cnt  = hdr_len;
                    walk_d.term = hdr_term;
                    walk_d.nxt  = hdr_next;
                    if (hdr_len != '0) begin
                        walk_d.st   = ST_FETCH_PAY;
                        walk_d.addr = step_addr;
                    end else if (hdr_term) begin
                        walk_d.st = ST_DONE;
                    end else begin
                        walk_d.addr = hdr_next;
                    end
                end
            end
            ST_FETCH_PAY: begin
                if (mem_valid_i) begin
                    walk_d.data = mem_data_i;
                    walk_d.st   = ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (cmd_ready_i) begin
                    walk_d.cnt = walk_q.cnt - LEN_ONE;
                    if (walk_q.cnt != LEN_ONE) begin
                        walk_d.st   = ST_FETCH_PAY;
                        walk_d.addr = step_addr;
                    end else if (walk_q.term) begin
                        walk_d.st = ST_DONE;
                    end else begin
                        walk_d.st   = ST_FETCH_HDR;
                        walk_d.addr = walk_q.nxt;
                    end
                end
            end
            ST_DONE: walk_d.st = ST_IDLE;
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{st: ST_IDLE, addr: '0, nxt: '0, cnt: '0, term: 1'b0, data: '0, err: 1'b0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy_o      = (walk_q.st != ST_IDLE);
    assign done_o      = (walk_q.st == ST_DONE);
    assign err_o       = walk_q.err;
    assign mem_req_o   = (walk_q.st == ST_FETCH_HDR) || (walk_q.st == ST_FETCH_PAY);
    assign mem_addr_o  = walk_q.addr;
    assign cmd_valid_o = (walk_q.st == ST_PUSH);
    assign cmd_data_o  = walk_q.data;

    // R9: an unanswered read keeps its request and address
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

    // R9: never a read and a pending output word together
    p_req_vs_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && cmd_valid_o));

    // R4: a stalled word is neither dropped nor altered
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o));

    // R5: done lasts one cycle and the walker is idle afterwards
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R8: an illegal start leaves the bus quiet
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && !mem_req_o && !cmd_valid_o);

    // R2: issued addresses are word aligned
    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> mem_addr_o[1:0] == 2'b00);

    // R10: a start during a walk leaves the current address alone
    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !mem_valid_i && !cmd_ready_i |=> $stable(mem_addr_o));
endmodule

// File: tb/cmd_list_walker_tb.sv
`timescale 1ns/1ps
module cmd_list_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic        dir_from_ram_i = 1'b1;
    logic [2:0]  port_i = 3'd2;
    logic        busy_o, done_o, err_o, mem_req_o, cmd_valid_o;
    logic [20:0] mem_addr_o;
    logic        mem_valid_i = 1'b0;
    logic [31:0] mem_data_i = '0;
    logic [31:0] cmd_data_o;
    logic        cmd_ready_i = 1'b0;

    always #2 clk = ~clk;

    cmd_list_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .dir_from_ram_i(dir_from_ram_i), .port_i(port_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i),
        .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i)
    );

    logic [31:0] mem [0:255];
    logic [20:0] fetch_log [0:63];
    logic [31:0] word_log  [0:63];
    logic [20:0] ef [0:63];
    logic [31:0] ew [0:63];
    int n_fetch = 0, n_word = 0, nef = 0, nexw = 0;
    int lat_cfg = 0, stall_mode = 0, cyc = 0;
    bit stall_bad = 0;
    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // RAM model: answers after lat_cfg cycles, logs each answered address
    initial begin
        int cnt;
        cnt = -1;
        forever begin
            @(negedge clk);
            if (mem_valid_i) begin
                mem_valid_i = 1'b0;
                cnt = -1;
            end else if (mem_req_o) begin
                if (cnt < 0) cnt = lat_cfg;
                if (cnt == 0) begin
                    mem_valid_i = 1'b1;
                    mem_data_i  = mem[mem_addr_o[9:2]];
                    if (n_fetch < 64) fetch_log[n_fetch] = mem_addr_o;
                    n_fetch++;
                end else begin
                    cnt--;
                end
            end
        end
    end

    // Command sink: ready pattern per stall_mode, logs accepted words
    initial begin
        bit pv, pr;
        logic [31:0] pd;
        bit rdy;
        pv = 0; pr = 0; pd = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pv && !pr && !(cmd_valid_o && cmd_data_o == pd)) stall_bad = 1;
            case (stall_mode)
                0: rdy = 1'b1;
                1: rdy = (cyc % 3 == 0);
                default: rdy = ((cyc * 7) % 5) < 2;
            endcase
            cmd_ready_i = rdy;
            if (cmd_valid_o && rdy) begin
                if (n_word < 64) word_log[n_word] = cmd_data_o;
                n_word++;
            end
            pv = cmd_valid_o; pr = rdy; pd = cmd_data_o;
        end
    end

    task automatic expect_walk(input logic [31:0] base);
        logic [20:0] a;
        logic [31:0] h;
        nef = 0; nexw = 0;
        a = base[20:0] & 21'h1FFFFC;
        for (int k = 0; k < 16; k++) begin
            ef[nef] = a; nef++;
            h = mem[a[9:2]];
            for (int i = 0; i < int'(h[31:24]); i++) begin
                a = (a + 21'd4) & 21'h1FFFFC;
                ef[nef] = a; nef++;
                ew[nexw] = mem[a[9:2]]; nexw++;
            end
            if (h[23]) break;
            a = h[20:0] & 21'h1FFFFC;
        end
    endtask

    task automatic run_walk(input logic [31:0] base, input int lat, input int sm, input bit restart);
        bit seen;
        lat_cfg = lat; stall_mode = sm;
        n_fetch = 0; n_word = 0; stall_bad = 0;
        expect_walk(base);
        @(negedge clk);
        dir_from_ram_i = 1'b1; port_i = 3'd2; base_i = base; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o == 1'b1, "R2", "request after start", 64'(mem_req_o), 64'd1);
        chk(mem_addr_o == ef[0], "R2", "first address", 64'(mem_addr_o), 64'(ef[0]));
        if (restart) begin
            repeat (2) @(negedge clk);
            base_i = 32'h0000_0200; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (done_o) begin seen = 1; break; end
        end
        chk(seen, "R5", "done pulse seen", 64'(seen), 64'd1);
        @(negedge clk);
        chk(!done_o && !busy_o, "R5", "done one cycle then idle", 64'({done_o, busy_o}), 64'd0);
        chk(n_fetch == nef, restart ? "R10" : "R3/R6", "fetch count", 64'(n_fetch), 64'(nef));
        for (int i = 0; i < nef && i < n_fetch; i++)
            chk(fetch_log[i] == ef[i], "R3/R6", "fetch address", 64'(fetch_log[i]), 64'(ef[i]));
        chk(n_word == nexw, restart ? "R10" : "R4/R7", "word count", 64'(n_word), 64'(nexw));
        for (int i = 0; i < nexw && i < n_word; i++)
            chk(word_log[i] == ew[i], "R4/R7", "payload word", 64'(word_log[i]), 64'(ew[i]));
        chk(stall_bad == 0, "R4", "word held under backpressure", 64'(stall_bad), 64'd0);
    endtask

    task automatic run_bad(input bit dir, input logic [2:0] prt);
        n_fetch = 0; n_word = 0;
        @(negedge clk);
        dir_from_ram_i = dir; port_i = prt; base_i = 32'h10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(err_o && !busy_o && !mem_req_o, "R8", "error pulse, no walk",
            64'({err_o, busy_o, mem_req_o}), 64'b100);
        @(negedge clk);
        chk(!err_o, "R8", "error pulse one cycle", 64'(err_o), 64'd0);
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (done_o || busy_o) begin
                chk(0, "R8", "unexpected activity", 64'({done_o, busy_o}), 64'd0);
                break;
            end
        end
        chk(n_fetch == 0 && n_word == 0, "R8", "no reads or words",
            64'(n_fetch + n_word), 64'd0);
        dir_from_ram_i = 1'b1; port_i = 3'd2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i * 3);
        // chain at 0x10: two words, then empty link at 0x40, then three words, last
        mem[4]   = 32'h0200_0040;
        mem[16]  = 32'h0000_0080;
        mem[32]  = 32'h038A_BCDC;
        // single empty terminating packet at 0x200
        mem[128] = 32'h0080_0000;
        // packet at 0x1FFFFC wraps its payload to 0x0, pointer with high junk bits
        mem[255] = 32'h0160_0303;
        mem[192] = 32'h0180_0000;

        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_o && !cmd_valid_o && !done_o && !err_o, "R1",
            "reset outputs", 64'({busy_o, mem_req_o, cmd_valid_o, done_o, err_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_o && !cmd_valid_o, "R1", "idle after reset",
            64'({busy_o, mem_req_o, cmd_valid_o}), 64'd0);

        for (int lat = 0; lat < 4; lat++) begin
            for (int sm = 0; sm < 3; sm++) begin
                run_walk(32'hFFE0_0013, lat, sm, 1'b0);
                run_walk(32'h0000_0200, lat, sm, 1'b0);
                run_walk(32'h001F_FFFC, lat, sm, 1'b0);
            end
        end
        run_walk(32'h0000_0010, 2, 1, 1'b1);
        run_bad(1'b0, 3'd2);
        run_bad(1'b1, 3'd5);
        run_bad(1'b0, 3'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule